// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

A small storage register whose contents can be held, loaded as a word, or moved one place toward either end on each rising clock edge. A two-bit mode input picks the operation. Each end has its own serial input. The bit shifted in at the high end comes from `ser_in_hi`, and the bit shifted in at the low end comes from `ser_in_lo`. The same unit can therefore turn a word into a bit stream or a bit stream into a word.

The register is `W` bits wide, 4 by default. Bit `W-1` is the high end and bit 0 is the low end. Each bit's next value is picked by its own four-way selector, fed by:
- the bit itself,
- its upper neighbour,
- its lower neighbour,
- its parallel input.

An active-low clear empties the register immediately, without waiting for a clock edge. The mode and data pins are plain levels, sampled at the clock edge. There is no handshake, because every edge consumes the inputs present at that edge.

Top module: `usr_shift_reg`

## Requirements
- R1: With `mode` = 2'b11, a rising edge copies `par_in` into `q`.
- R2: With `mode` = 2'b10, a rising edge moves each bit one place toward bit 0, and `ser_in_hi` enters bit `W-1`.
- R3: With `mode` = 2'b01, a rising edge moves each bit one place toward bit `W-1`, and `ser_in_lo` enters bit 0.
- R4: With `mode` = 2'b00, a rising edge leaves `q` unchanged, whatever `par_in` and the serial inputs are.
- R5: Driving `clr_n` low sets `q` to all zeros at once, with no clock edge needed.
- R6: While `clr_n` is low, rising edges leave `q` at zero in every mode.
- R7: `q` changes only on a rising edge. Changes to `mode`, `par_in` or the serial inputs between edges have no effect on `q` until the next edge.
- R8: A serial link can be formed from two units on one clock:
  - the sender's bit 0 is wired to the receiver's `ser_in_hi`;
  - both units are in `mode` 2'b10.
  After `W` edges, the receiver holds the word the sender started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low, overrides every mode |
| mode | input | 2 | 00 hold, 01 move toward high end, 10 move toward low end, 11 load |
| ser_in_hi | input | 1 | Serial bit entering bit W-1 in mode 10 |
| ser_in_lo | input | 1 | Serial bit entering bit 0 in mode 01 |
| par_in | input | W | Word copied in mode 11 |
| q | output | W | Register contents |

## Verification
The bench builds both of its units at the default width of 4. This keeps the full value space of the register small: loads of all-ones, alternating patterns and single bits show every bit's selector in all four positions. The default width also exercises both end bits, whose outer neighbours are the serial inputs rather than other bits. The second unit is wired to the first unit's low bit. This brings a full word transfer through the serial path within four edges, so the ordering of the bits at both ends can be checked in one short scenario.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_TO_HI = 2'b01,
    MODE_TO_LO = 2'b10,
    MODE_LOAD  = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_bit_sel.sv
module usr_bit_sel
  import usr_pkg::*;
(
  input  usr_mode_e sel,
  input  logic      keep,
  input  logic      from_hi,
  input  logic      from_lo,
  input  logic      load,
  output logic      nxt
);
  always_comb begin
    unique case (sel)
      MODE_HOLD:  nxt = keep;
      MODE_TO_HI: nxt = from_lo;
      MODE_TO_LO: nxt = from_hi;
      default:    nxt = load;
    endcase
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_in_hi,
  input  logic         ser_in_lo,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);
  localparam int TOP = W - 1;

  usr_mode_e   sel;
  logic [W-1:0] nxt;

  assign sel = usr_mode_e'(mode);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic up_src;
    logic dn_src;
    if (i == TOP) begin : g_top
      assign up_src = ser_in_hi;
    end else begin : g_mid_up
      assign up_src = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign dn_src = ser_in_lo;
    end else begin : g_mid_dn
      assign dn_src = q[i-1];
    end

    usr_bit_sel u_sel (
      .sel     (sel),
      .keep    (q[i]),
      .from_hi (up_src),
      .from_lo (dn_src),
      .load    (par_in[i]),
      .nxt     (nxt[i])
    );

    usr_cell u_cell (
      .clk   (clk),
      .clr_n (clr_n),
      .d     (nxt[i]),
      .q     (q[i])
    );
  end

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b11 |=> q == $past(par_in)); // R1
  AST_SHIFT_LO: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b10 |=> q == {$past(ser_in_hi), $past(q[W-1:1])}); // R2
  AST_SHIFT_HI: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b01 |=> q == {$past(q[W-2:0]), $past(ser_in_lo)}); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b00 |=> $stable(q)); // R4

  always @(negedge clk) begin
    if (!clr_n) begin
      AST_CLEAR_ZERO: assert (q == '0); // R5
    end
  end
endmodule

// File: tb/sim_usr_shift_reg.sv
module sim_usr_shift_reg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         ser_in_hi = 1'b0;
  logic         ser_in_lo = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q;
  logic [1:0]   mode_r = 2'b00;
  logic [W-1:0] q_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usr_shift_reg #(.W(W)) u0 (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_in_hi(ser_in_hi),
    .ser_in_lo(ser_in_lo), .par_in(par_in), .q(q)
  );

  usr_shift_reg #(.W(W)) u1 (
    .clk(clk), .clr_n(clr_n), .mode(mode_r), .ser_in_hi(q[0]),
    .ser_in_lo(1'b0), .par_in('0), .q(q_r)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive inputs, wait one edge, sample 2 ns later
  task automatic step(input logic [1:0] m, input logic [W-1:0] p, input logic hi, input logic lo);
    mode = m; par_in = p; ser_in_hi = hi; ser_in_lo = lo;
    @(posedge clk); #2;
  endtask

  task automatic t_reset;
    #1;
    chk("R5 reset state", q, '0);
    @(posedge clk); #2;
    clr_n = 1'b1;
  endtask

  task automatic t_load;
    step(2'b11, 4'b1010, 1'b0, 1'b0); chk("R1 load 1010", q, 4'b1010);
    step(2'b11, 4'b0101, 1'b1, 1'b1); chk("R1 load 0101", q, 4'b0101);
    step(2'b11, 4'b1111, 1'b0, 1'b0); chk("R1 load 1111", q, 4'b1111);
  endtask

  task automatic t_hold;
    step(2'b11, 4'b0110, 1'b0, 1'b0);
    step(2'b00, 4'b1001, 1'b1, 1'b1); chk("R4 hold ignores inputs", q, 4'b0110);
    step(2'b00, 4'b0000, 1'b0, 1'b0); chk("R4 hold second edge", q, 4'b0110);
  endtask

  task automatic t_shift_lo;
    step(2'b11, 4'b1000, 1'b0, 1'b0);
    step(2'b10, 4'b0000, 1'b1, 1'b0); chk("R2 move toward bit0, hi enters", q, 4'b1100);
    step(2'b10, 4'b0000, 1'b0, 1'b1); chk("R2 second move", q, 4'b0110);
    step(2'b10, 4'b0000, 1'b0, 1'b0); chk("R2 third move", q, 4'b0011);
    step(2'b10, 4'b0000, 1'b0, 1'b0); chk("R2 bit0 falls off", q, 4'b0001);
  endtask

  task automatic t_shift_hi;
    step(2'b11, 4'b0001, 1'b0, 1'b0);
    step(2'b01, 4'b0000, 1'b0, 1'b1); chk("R3 move toward top, lo enters", q, 4'b0011);
    step(2'b01, 4'b0000, 1'b1, 1'b0); chk("R3 second move", q, 4'b0110);
    step(2'b01, 4'b0000, 1'b0, 1'b0); chk("R3 third move", q, 4'b1100);
    step(2'b01, 4'b0000, 1'b0, 1'b0); chk("R3 top bit falls off", q, 4'b1000);
  endtask

  task automatic t_clear;
    step(2'b11, 4'b1011, 1'b0, 1'b0);
    clr_n = 1'b0; #1;
    chk("R5 clear without edge", q, '0);
    step(2'b11, 4'b1111, 1'b1, 1'b1); chk("R6 clear beats load", q, '0);
    step(2'b01, 4'b0000, 1'b1, 1'b1); chk("R6 clear beats shift", q, '0);
    clr_n = 1'b1;
    step(2'b11, 4'b0111, 1'b0, 1'b0); chk("R6 normal after release", q, 4'b0111);
  endtask

  task automatic t_mid_cycle;
    step(2'b11, 4'b1001, 1'b0, 1'b0);
    mode = 2'b11; par_in = 4'b0110; ser_in_hi = 1'b1; ser_in_lo = 1'b1; #3;
    chk("R7 no change between edges", q, 4'b1001);
    mode = 2'b10; #2;
    chk("R7 mode change between edges", q, 4'b1001);
    step(2'b11, 4'b0110, 1'b0, 1'b0); chk("R7 change at edge", q, 4'b0110);
  endtask

  task automatic t_link;
    step(2'b11, 4'b1101, 1'b0, 1'b0);
    mode_r = 2'b10;
    for (int k = 0; k < W; k++) step(2'b10, 4'b0000, 1'b0, 1'b0);
    mode_r = 2'b00;
    chk("R8 receiver holds word", q_r, 4'b1101);
    step(2'b11, 4'b0010, 1'b0, 1'b0);
    mode_r = 2'b10;
    for (int k = 0; k < W; k++) step(2'b10, 4'b0000, 1'b0, 1'b0);
    mode_r = 2'b00;
    chk("R8 second word", q_r, 4'b0010);
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_shift_lo();
    t_shift_hi();
    t_clear();
    t_mid_cycle();
    t_link();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule